// File: doc/BRIEF.md
# Write Burst Length and Ordering Checker

This passive monitor watches the write address channel and the write data channel of a memory-mapped bus and reports three classes of protocol fault. It pairs each address handshake with the data burst that carries the same ID and compares the number of data beats with the length field of that address. Data may arrive before or after its address. It also confirms that data bursts start in the same order as their addresses were issued, and that the master never has more data bursts open at once than a configured interleave depth.

The block drives nothing on the bus. Pending addresses whose data has not started wait in an in-order queue. Every open data burst occupies one slot of a small table that holds its ID, its beat count, whether its address is known and whether its last beat has been seen. Each fault class has a one-cycle pulse output and a sticky flag that stays set until reset.

Top module: `wbc_burst_checker`

## Requirements
- R1: The length field encodes beats minus one. When a data beat with the last flag set is accepted, its zero-based index within the burst is compared with the length of its bound address, and a length fault is raised if they differ.
- R2: When a data beat without the last flag is accepted, its address is bound and its zero-based index equals the length field, a length fault is raised because the last flag was missing.
- R3: When an address is accepted for a data burst that has already delivered its last beat, a length fault is raised if the index of that last beat differs from the new length field. The slot is then released whether or not a fault was raised.
- R4: When the first beat of a burst is accepted while addresses are pending, it is matched against the oldest pending address. An order fault is raised if the IDs differ, and the burst is still bound to that address.
- R5: Bursts that start before their addresses are bound to later addresses in the order in which they started. An order fault is raised when an accepted address carries an ID other than that of the oldest unbound burst.
- R6: A slot is held from the first beat of a burst until both its address and its last beat have been seen. A first beat accepted while all WDEPTH slots are held raises a depth fault and is not tracked.
- R7: A transfer on either channel counts only on a clock edge where its valid and ready are both high. A valid without ready changes neither state nor the error outputs.
- R8: When an address and a data beat are accepted on the same edge, the address is applied first. A first beat can therefore bind to an address that arrives on the same edge.
- R9: A fault shows as a pulse in the cycle after the edge that accepted the offending transfer. The matching sticky flag rises together with the pulse and stays high until reset.
- R10: While rst_n is low, the queues, the slot table, the pulses and the sticky flags are cleared.
- R11: Correct traffic raises no fault, whether addresses come first, data comes first, or bursts interleave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write address ID |
| aw_len | input | LEN_W | Burst length minus one |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_id | input | ID_W | Write data ID |
| w_last | input | 1 | Last beat of a data burst |
| len_err_pulse | output | 1 | Length fault pulse |
| order_err_pulse | output | 1 | Order fault pulse |
| depth_err_pulse | output | 1 | Interleave depth fault pulse |
| len_err_seen | output | 1 | Sticky length fault |
| order_err_seen | output | 1 | Sticky order fault |
| depth_err_seen | output | 1 | Sticky depth fault |

## Verification
The bench builds the checker with 2-bit IDs, a 3-bit length field, an interleave depth of 2 and an address queue of 4. The small length field makes it possible to sweep every length (1 to 8 beats) against every delivered beat count from 1 to 8, with the address first and with the data first. For each beat the bench computes arithmetically whether a fault is expected. A depth of 2 means a third concurrent burst is enough to reach the slot-exhaustion case. This includes slots that are still held by finished bursts waiting for their address.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   // Index of each fault class in the internal event vector
   typedef enum int unsigned {
      EV_LEN   = 0,
      EV_ORDER = 1,
      EV_DEPTH = 2
   } wbc_ev_e;

   localparam int unsigned EV_COUNT = 3;
endpackage

// File: rtl/wbc_addr_fifo.sv
module wbc_addr_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int unsigned PW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wbc_addr_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [PW:0]   count;
   logic          do_push, do_pop;

   // A push and a pop on an empty queue pass straight through
   assign do_pop  = pop && !empty;
   assign do_push = push && !(pop && empty) && (!full || pop);
   assign empty   = (count == '0);
   assign full    = (count == (PW+1)'(DEPTH));
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
         mem    <= '{default: '0};
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= din;
            wr_ptr      <= wr_ptr + PW'(1);
         end
         if (do_pop) rd_ptr <= rd_ptr + PW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + (PW+1)'(1);
            2'b01:   count <= count - (PW+1)'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/wbc_err_flags.sv
module wbc_err_flags #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   output logic [N-1:0] pulse,
   output logic [N-1:0] sticky
);
   for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pulse[g]  <= 1'b0;
            sticky[g] <= 1'b0;
         end else begin
            pulse[g]  <= evt[g];
            sticky[g] <= sticky[g] | evt[g];
         end
      end
   end
endmodule

// File: rtl/wbc_burst_checker.sv
module wbc_burst_checker
   import wbc_pkg::*;
#(
   parameter int unsigned ID_W     = 4,
   parameter int unsigned LEN_W    = 8,
   parameter int unsigned WDEPTH   = 4,
   parameter int unsigned AQ_DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             aw_valid,
   input  logic             aw_ready,
   input  logic [ID_W-1:0]  aw_id,
   input  logic [LEN_W-1:0] aw_len,
   input  logic             w_valid,
   input  logic             w_ready,
   input  logic [ID_W-1:0]  w_id,
   input  logic             w_last,
   output logic             len_err_pulse,
   output logic             order_err_pulse,
   output logic             depth_err_pulse,
   output logic             len_err_seen,
   output logic             order_err_seen,
   output logic             depth_err_seen
);
   localparam int unsigned CNT_W = LEN_W + 1;
   localparam int unsigned TK_W  = $clog2(WDEPTH) + 1;
   localparam int unsigned SW_W  = (WDEPTH > 1) ? $clog2(WDEPTH) : 1;
   localparam int unsigned OCC_W = $clog2(WDEPTH + 1);
   localparam int unsigned AE_W  = ID_W + LEN_W;

   if (ID_W < 1 || LEN_W < 1) begin : g_bad_width
      $error("wbc_burst_checker: ID_W and LEN_W must be at least 1");
   end
   if (WDEPTH < 1 || (WDEPTH & (WDEPTH - 1)) != 0) begin : g_bad_wdepth
      $error("wbc_burst_checker: WDEPTH must be a power of two");
   end

   // Slot table state
   logic [WDEPTH-1:0] s_vld, s_bnd, s_done;
   logic [ID_W-1:0]   s_id  [WDEPTH];
   logic [LEN_W-1:0]  s_len [WDEPTH];
   logic [CNT_W-1:0]  s_cnt [WDEPTH];
   logic [TK_W-1:0]   s_tk  [WDEPTH];
   logic [TK_W-1:0]   issue, serve;

   logic [WDEPTH-1:0] n_vld, n_bnd, n_done;
   logic [ID_W-1:0]   n_id  [WDEPTH];
   logic [LEN_W-1:0]  n_len [WDEPTH];
   logic [CNT_W-1:0]  n_cnt [WDEPTH];
   logic [TK_W-1:0]   n_tk  [WDEPTH];
   logic [TK_W-1:0]   n_issue, n_serve;

   logic                aw_hs, w_hs;
   logic                q_push, q_pop, q_empty, q_full;
   logic [AE_W-1:0]     q_dout;
   logic [EV_COUNT-1:0] ev, pulse, sticky;

   assign aw_hs = aw_valid && aw_ready;
   assign w_hs  = w_valid && w_ready;

   wbc_addr_fifo #(.W(AE_W), .DEPTH(AQ_DEPTH)) u_addr_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   ({aw_id, aw_len}),
      .pop   (q_pop),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full)
   );

   always_comb begin
      logic             a_hit, w_hit, f_hit, hd_avail;
      logic [SW_W-1:0]  a_sel, w_sel;
      logic [OCC_W-1:0] occ;
      logic [CNT_W-1:0] b;
      logic [ID_W-1:0]  hd_id;
      logic [LEN_W-1:0] hd_len;

      n_vld   = s_vld;
      n_bnd   = s_bnd;
      n_done  = s_done;
      n_id    = s_id;
      n_len   = s_len;
      n_cnt   = s_cnt;
      n_tk    = s_tk;
      n_issue = issue;
      n_serve = serve;
      ev      = '0;
      q_push  = 1'b0;
      q_pop   = 1'b0;
      a_hit   = 1'b0;
      w_hit   = 1'b0;
      f_hit   = 1'b0;
      a_sel   = '0;
      w_sel   = '0;
      occ     = '0;
      b       = '0;

      // Address side first: bind to the oldest unbound burst, else queue it
      if (aw_hs) begin
         for (int i = 0; i < WDEPTH; i++) begin
            if (!a_hit && s_vld[i] && !s_bnd[i] && s_tk[i] == serve) begin
               a_hit = 1'b1;
               a_sel = i[SW_W-1:0];
            end
         end
         if (a_hit) begin
            if (s_id[a_sel] != aw_id) ev[EV_ORDER] = 1'b1;
            n_serve = serve + TK_W'(1);
            if (s_done[a_sel]) begin
               if (s_cnt[a_sel] != CNT_W'(aw_len)) ev[EV_LEN] = 1'b1;
               n_vld[a_sel]  = 1'b0;
               n_bnd[a_sel]  = 1'b0;
               n_done[a_sel] = 1'b0;
            end else begin
               n_bnd[a_sel] = 1'b1;
               n_len[a_sel] = aw_len;
            end
         end else begin
            q_push = 1'b1;
         end
      end

      // Queue head as seen after the address step
      hd_avail        = !q_empty || q_push;
      {hd_id, hd_len} = q_empty ? {aw_id, aw_len} : q_dout;

      // Data side, applied to the post-address state
      if (w_hs) begin
         for (int i = 0; i < WDEPTH; i++) begin
            if (!w_hit && n_vld[i] && !n_done[i] && n_id[i] == w_id) begin
               w_hit = 1'b1;
               w_sel = i[SW_W-1:0];
            end
         end
         if (!w_hit) begin
            for (int i = 0; i < WDEPTH; i++) occ = occ + OCC_W'(n_vld[i]);
            if (occ == OCC_W'(WDEPTH)) begin
               ev[EV_DEPTH] = 1'b1;
            end else begin
               for (int i = 0; i < WDEPTH; i++) begin
                  if (!f_hit && !n_vld[i]) begin
                     f_hit = 1'b1;
                     w_sel = i[SW_W-1:0];
                  end
               end
               w_hit         = 1'b1;
               n_vld[w_sel]  = 1'b1;
               n_done[w_sel] = 1'b0;
               n_id[w_sel]   = w_id;
               n_cnt[w_sel]  = '0;
               if (hd_avail) begin
                  q_pop = 1'b1;
                  if (hd_id != w_id) ev[EV_ORDER] = 1'b1;
                  n_bnd[w_sel] = 1'b1;
                  n_len[w_sel] = hd_len;
               end else begin
                  n_bnd[w_sel] = 1'b0;
                  n_tk[w_sel]  = n_issue;
                  n_issue      = n_issue + TK_W'(1);
               end
            end
         end
         if (w_hit) begin
            b = n_cnt[w_sel];
            if (n_bnd[w_sel]) begin
               if (w_last) begin
                  if (b != CNT_W'(n_len[w_sel])) ev[EV_LEN] = 1'b1;
                  n_vld[w_sel] = 1'b0;
                  n_bnd[w_sel] = 1'b0;
               end else begin
                  if (b == CNT_W'(n_len[w_sel])) ev[EV_LEN] = 1'b1;
                  n_cnt[w_sel] = (b == '1) ? b : b + CNT_W'(1);
               end
            end else begin
               if (w_last) n_done[w_sel] = 1'b1;
               else        n_cnt[w_sel]  = (b == '1) ? b : b + CNT_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_vld  <= '0;
         s_bnd  <= '0;
         s_done <= '0;
         s_id   <= '{default: '0};
         s_len  <= '{default: '0};
         s_cnt  <= '{default: '0};
         s_tk   <= '{default: '0};
         issue  <= '0;
         serve  <= '0;
      end else begin
         s_vld  <= n_vld;
         s_bnd  <= n_bnd;
         s_done <= n_done;
         s_id   <= n_id;
         s_len  <= n_len;
         s_cnt  <= n_cnt;
         s_tk   <= n_tk;
         issue  <= n_issue;
         serve  <= n_serve;
      end
   end

   wbc_err_flags #(.N(EV_COUNT)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (ev),
      .pulse  (pulse),
      .sticky (sticky)
   );

   assign len_err_pulse   = pulse[EV_LEN];
   assign order_err_pulse = pulse[EV_ORDER];
   assign depth_err_pulse = pulse[EV_DEPTH];
   assign len_err_seen    = sticky[EV_LEN];
   assign order_err_seen  = sticky[EV_ORDER];
   assign depth_err_seen  = sticky[EV_DEPTH];

   logic unused_full;
   assign unused_full = q_full;
endmodule

// File: rtl/wbc_burst_checker_sva.sv
module wbc_burst_checker_sva (
   input logic clk,
   input logic rst_n,
   input logic aw_valid,
   input logic aw_ready,
   input logic w_valid,
   input logic w_ready,
   input logic len_err_pulse,
   input logic order_err_pulse,
   input logic depth_err_pulse,
   input logic len_err_seen,
   input logic order_err_seen,
   input logic depth_err_seen
);
   AST_LEN_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      len_err_pulse |-> $past((aw_valid && aw_ready) || (w_valid && w_ready))); // R7
   AST_ORDER_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      order_err_pulse |-> $past((aw_valid && aw_ready) || (w_valid && w_ready))); // R4
   AST_DEPTH_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      depth_err_pulse |-> $past(w_valid && w_ready)); // R6
   AST_LEN_PULSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      len_err_pulse |-> len_err_seen); // R9
   AST_ORDER_PULSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      order_err_pulse |-> order_err_seen); // R9
   AST_DEPTH_PULSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      depth_err_pulse |-> depth_err_seen); // R9
   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (len_err_seen || order_err_seen || depth_err_seen) |=>
      ($countones({len_err_seen, order_err_seen, depth_err_seen}) >=
       $countones($past({len_err_seen, order_err_seen, depth_err_seen})))); // R9
endmodule

bind wbc_burst_checker wbc_burst_checker_sva u_sva (
   .clk             (clk),
   .rst_n           (rst_n),
   .aw_valid        (aw_valid),
   .aw_ready        (aw_ready),
   .w_valid         (w_valid),
   .w_ready         (w_ready),
   .len_err_pulse   (len_err_pulse),
   .order_err_pulse (order_err_pulse),
   .depth_err_pulse (depth_err_pulse),
   .len_err_seen    (len_err_seen),
   .order_err_seen  (order_err_seen),
   .depth_err_seen  (depth_err_seen)
);

// File: tb/tb_wbc_burst_checker.sv
`timescale 1ns/1ps
module tb_wbc_burst_checker;
   localparam int unsigned ID_W = 2, LEN_W = 3, WDEPTH = 2, AQ_DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0, w_last = 0;
   logic [ID_W-1:0]  aw_id = '0, w_id = '0;
   logic [LEN_W-1:0] aw_len = '0;
   logic len_p, ord_p, dep_p, len_s, ord_s, dep_s;
   logic g_len, g_ord, g_dep;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   wbc_burst_checker #(.ID_W(ID_W), .LEN_W(LEN_W), .WDEPTH(WDEPTH), .AQ_DEPTH(AQ_DEPTH)) dut (
      .clk(clk), .rst_n(rst_n),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len),
      .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_last(w_last),
      .len_err_pulse(len_p), .order_err_pulse(ord_p), .depth_err_pulse(dep_p),
      .len_err_seen(len_s), .order_err_seen(ord_s), .depth_err_seen(dep_s)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   // Drive one cycle from a negedge, sample the pulses at the next negedge
   task automatic step(input logic av, input logic ar, input int aid, input int alen,
                       input logic wv, input logic wr, input int wid, input logic wl);
      aw_valid = av; aw_ready = ar; aw_id = aid[ID_W-1:0]; aw_len = alen[LEN_W-1:0];
      w_valid = wv; w_ready = wr; w_id = wid[ID_W-1:0]; w_last = wl;
      @(negedge clk);
      g_len = len_p; g_ord = ord_p; g_dep = dep_p;
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic aw(input int aid, input int alen);
      step(1, 1, aid, alen, 0, 0, 0, 0);
   endtask

   task automatic wb(input int wid, input logic wl);
      step(0, 0, 0, 0, 1, 1, wid, wl);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle();
      idle();
      rst_n = 1'b1;
      idle();
      chk("R10", "sticky after reset", len_s | ord_s | dep_s, 1'b0);
      chk("R10", "pulse after reset", len_p | ord_p | dep_p, 1'b0);
   endtask

   initial begin
      logic any_err;
      @(negedge clk);
      do_reset();

      // Address-first sweep over every length and delivered beat count
      for (int len = 0; len < 8; len++) begin
         for (int n = 1; n <= 8; n++) begin
            do_reset();
            aw(1, len);
            chk("R11", "no fault on address", g_len | g_ord | g_dep, 1'b0);
            any_err = 1'b0;
            for (int bi = 0; bi < n; bi++) begin
               logic last, exp;
               last = (bi == n - 1);
               if (bi == 1) begin
                  step(0, 0, 0, 0, 1, 0, 1, 1); // R7: valid without ready
                  chk("R7", "stalled beat ignored", g_len, 1'b0);
               end
               exp = last ? (bi != len) : (bi == len);
               any_err = any_err | exp;
               wb(1, last);
               if (last) chk("R1", "last beat length", g_len, exp);
               else      chk("R2", "missing last", g_len, exp);
               chk("R11", "no order fault", g_ord, 1'b0);
            end
            idle();
            chk("R9", "sticky length", len_s, any_err);
         end
      end

      // Data-first sweep: the address arrives after the last beat
      for (int len = 0; len < 8; len++) begin
         for (int n = 1; n <= 8; n++) begin
            do_reset();
            for (int bi = 0; bi < n; bi++) begin
               wb(2, bi == n - 1);
               chk("R11", "unbound beat quiet", g_len | g_ord | g_dep, 1'b0);
            end
            aw(2, len);
            chk("R3", "late address length", g_len, (n - 1) != len);
            chk("R3", "late address order", g_ord, 1'b0);
         end
      end

      // R4: first beat against the oldest pending address
      do_reset();
      aw(1, 0); aw(2, 0);
      wb(2, 1);
      chk("R4", "wrong first burst", g_ord, 1'b1);
      do_reset();
      aw(1, 0); aw(2, 0);
      wb(1, 1);
      chk("R4", "right first burst", g_ord | g_len, 1'b0);
      wb(2, 1);
      chk("R4", "second burst", g_ord | g_len, 1'b0);

      // R5: data-first bursts bind in start order
      do_reset();
      wb(1, 0); wb(2, 0);
      aw(2, 1);
      chk("R5", "address skips oldest", g_ord, 1'b1);
      do_reset();
      wb(1, 0); wb(2, 0);
      aw(1, 1);
      chk("R5", "oldest bound", g_ord | g_len, 1'b0);
      aw(2, 1);
      chk("R5", "next bound", g_ord | g_len, 1'b0);
      wb(2, 1);
      chk("R11", "interleaved finish", g_ord | g_len, 1'b0);
      wb(1, 1);
      chk("R11", "interleaved finish", g_ord | g_len, 1'b0);

      // R6: interleave depth of two
      do_reset();
      aw(0, 3); aw(1, 3); aw(2, 0);
      wb(0, 0); wb(1, 0);
      chk("R6", "two open", g_dep, 1'b0);
      wb(2, 1);
      chk("R6", "third burst", g_dep, 1'b1);
      chk("R6", "no order on overflow", g_ord, 1'b0);
      wb(0, 0); wb(0, 0); wb(0, 1);
      chk("R6", "burst 0 done", g_len | g_dep, 1'b0);
      wb(2, 1);
      chk("R6", "slot reused", g_dep | g_ord | g_len, 1'b0);
      do_reset();
      wb(1, 1); wb(2, 1);
      wb(3, 1);
      chk("R6", "finished but unbound hold slots", g_dep, 1'b1);

      // R8: same-edge address and data
      do_reset();
      step(1, 1, 3, 0, 1, 1, 3, 1);
      chk("R8", "same edge match", g_len | g_ord | g_dep, 1'b0);
      step(1, 1, 1, 1, 1, 1, 1, 1);
      chk("R8", "same edge short burst", g_len, 1'b1);
      chk("R8", "same edge order", g_ord, 1'b0);

      // R7: address valid without ready is not queued
      do_reset();
      step(1, 0, 1, 0, 0, 0, 0, 0);
      wb(2, 1);
      chk("R7", "unaccepted address", g_ord, 1'b0);
      aw(2, 0);
      chk("R7", "late match", g_ord | g_len, 1'b0);

      // R9: sticky holds through clean traffic
      do_reset();
      aw(1, 0); wb(1, 0);
      chk("R9", "pulse", g_len, 1'b1);
      idle();
      chk("R9", "pulse is one cycle", len_p, 1'b0);
      wb(1, 1);
      aw(3, 0); wb(3, 1);
      idle();
      chk("R9", "sticky stays", len_s, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule